// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block turns one internal read or write request into exactly one external bus cycle. A cycle runs through an address phase with ALE high, an optional strobe delay, a strobe phase with RD or WR high, and a short tail. Each request carries its own settings: bus mode (multiplexed or demultiplexed, 8-bit or 16-bit data), external address width, ALE length, strobe delay, wait states, post-read idle time and whether the external ready input is honoured. A slow device can hold the strobe open for as long as it needs by keeping ready low.

The pins are given as separate signals. There is a dedicated address output, a shared address/data port with separate output, output-enable and input signals, and the ALE, RD and WR strobes. The requester gets one done pulse, and on a read it carries the returned data. A single-chip mode setting turns the external bus off. The requester only issues a request while busy is low.

Top module: `ebc_seq`

## Requirements
- R1: After reset, busy_o, done_o, ale_o, rd_o, wr_o and ad_oe_o are all low.
- R2: Mode codes 0, 5, 6 and 7 mean single-chip. An accepted request then makes no ALE, RD or WR activity. done_o goes high in the first cycle after acceptance, with rdata_o = 0.
- R3: Mode codes: 1 = demultiplexed 16-bit, 2 = multiplexed 16-bit, 3 = multiplexed 8-bit, 4 = demultiplexed 8-bit. In multiplexed modes, ad_o carries address bits [15:0] with ad_oe_o high while ALE is high. In demultiplexed modes, ad_oe_o stays low while ALE is high.
- R4: aw_sel_i codes 0/1/2/3 select 16/18/20/24 address bits. addr_o carries the request address with all higher bits cleared, and holds it unchanged for the whole cycle.
- R5: ALE is high for 1 clock, or for 2 clocks when ale_long_i = 1. It never overlaps RD or WR.
- R6: With rw_dly_i = 1, one clock with no ALE and no strobe lies between ALE falling and the strobe rising. With rw_dly_i = 0 there is none.
- R7: The strobe lasts 1 + wait_i clocks when ready is not holding the cycle (wait_i is 0 to 15).
- R8: With rdy_en_i = 1, ready is sampled on each rising edge once the wait states are spent. The strobe ends after the first such edge on which rdy_i is high. With rdy_en_i = 0, rdy_i has no effect.
- R9: On a write, ad_oe_o is high and ad_o carries the write data from the first clock after the address phase until one clock after WR falls. In 8-bit modes, ad_o = {8'h00, wdata_i[7:0]}.
- R10: On a read, rdata_o holds ad_i as sampled on the last strobe edge (zero-extended from ad_i[7:0] in 8-bit modes). In demultiplexed modes, ad_oe_o stays low for the whole read.
- R11: done_o rises A+D+S+T clocks after the acceptance edge, counted as the cycle index after that edge. A is the ALE length, D the strobe delay and S the strobe length. T is 1 for a write, and for a read it is tri_gap_i (0 or 1). ad_oe_o is low in the clock after RD falls.
- R12: done_o is high for exactly one clock per accepted request. A request is accepted only while busy_o is low; a request raised while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 24 | Request address |
| wdata_i | input | 16 | Write data |
| mode_i | input | 3 | Bus mode code |
| aw_sel_i | input | 2 | External address width code |
| wait_i | input | 4 | Wait states |
| ale_long_i | input | 1 | Two-clock ALE |
| rw_dly_i | input | 1 | One-clock strobe delay |
| tri_gap_i | input | 1 | Idle clock after a read |
| rdy_en_i | input | 1 | Honour rdy_i |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 16 | Read data |
| addr_o | output | 24 | Dedicated address port |
| ad_o | output | 16 | Shared port output value |
| ad_oe_o | output | 1 | Shared port output enable |
| ad_i | input | 16 | Shared port input value |
| ale_o | output | 1 | Address latch enable |
| rd_o | output | 1 | Read strobe, active high |
| wr_o | output | 1 | Write strobe, active high |
| rdy_i | input | 1 | External ready |

## Verification
A wrong sequencer state shows up at once as a stretched or shortened ALE, gap or strobe. The bench measures each of these per cycle, and the done latency shifts in the same transaction. A stale per-request setting, or an address that is masked wrongly, appears as a wrong ad_o or addr_o value during ALE or WR, in the very clock it is driven. A corrupted counter or ready path changes the strobe length by whole clocks and is caught when done arrives. A wrongly captured read byte shows in rdata_o in that same done clock.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  localparam int WAIT_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_DLY, ST_STRB, ST_HOLD, ST_TRI
  } ebc_state_e;

  typedef struct packed {
    logic              mux;
    logic              bus8;
    logic [WAIT_W-1:0] wt;
    logic              dly;
    logic              trist;
    logic              rdy_en;
  } ebc_cfg_t;
endpackage

// File: rtl/ebc_wait_ctr.sv
module ebc_wait_ctr #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ebc_addr_mask.sv
module ebc_addr_mask #(
  parameter int AW = 24
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    aw_sel_i,
  output logic [AW-1:0] addr_o
);
  localparam int LW = $clog2(AW + 1) + 1;
  logic [LW-1:0] lim;

  always_comb begin
    case (aw_sel_i)
      2'd0:    lim = LW'(16);
      2'd1:    lim = LW'(18);
      2'd2:    lim = LW'(20);
      default: lim = LW'(AW);
    endcase
  end

  for (genvar i = 0; i < AW; i++) begin : g_bit
    assign addr_o[i] = addr_i[i] & (lim > LW'(i));
  end
endmodule

// File: rtl/ebc_port_mux.sv
module ebc_port_mux #(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          ph_addr_i,
  input  logic          ph_wdrv_i,
  input  logic          mux_i,
  input  logic          bus8_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o
);
  localparam int HB = DW / 2;

  always_comb begin
    ad_o    = '0;
    ad_oe_o = 1'b0;
    if (ph_addr_i && mux_i) begin
      ad_o    = addr_i[DW-1:0];
      ad_oe_o = 1'b1;
    end else if (ph_wdrv_i) begin
      ad_o    = bus8_i ? {{(DW-HB){1'b0}}, wdata_i[HB-1:0]} : wdata_i;
      ad_oe_o = 1'b1;
    end
  end
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [2:0]        mode_i,
  input  logic [1:0]        aw_sel_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic              ale_long_i,
  input  logic              rw_dly_i,
  input  logic              tri_gap_i,
  input  logic              rdy_en_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DW-1:0]     rdata_o,
  output logic [AW-1:0]     addr_o,
  output logic [DW-1:0]     ad_o,
  output logic              ad_oe_o,
  input  logic [DW-1:0]     ad_i,
  output logic              ale_o,
  output logic              rd_o,
  output logic              wr_o,
  input  logic              rdy_i
);
  localparam int HB = DW / 2;

  ebc_state_e    state_q;
  ebc_cfg_t      cfg_q;
  logic [AW-1:0] addr_q, addr_m;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          we_q, ale_more_q, done_q;
  logic          ext, mode_mux, mode_b8, wt_zero, strb_end;

  // mode decode: 1..4 drive the bus, all other codes are single-chip
  assign ext      = (mode_i >= 3'd1) && (mode_i <= 3'd4);
  assign mode_mux = (mode_i == 3'd2) || (mode_i == 3'd3);
  assign mode_b8  = (mode_i == 3'd3) || (mode_i == 3'd4);

  ebc_addr_mask #(.AW(AW)) u_mask (
    .addr_i   (addr_i),
    .aw_sel_i (aw_sel_i),
    .addr_o   (addr_m)
  );

  ebc_wait_ctr #(.W(WAIT_W)) u_wait (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (state_q != ST_STRB),
    .val_i  (cfg_q.wt),
    .dec_i  ((state_q == ST_STRB) && !wt_zero),
    .zero_o (wt_zero)
  );

  assign strb_end = (state_q == ST_STRB) && wt_zero && (!cfg_q.rdy_en || rdy_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cfg_q      <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
      rdata_q    <= '0;
      we_q       <= 1'b0;
      ale_more_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          if (!ext) begin
            done_q  <= 1'b1;
            rdata_q <= '0;
          end else begin
            cfg_q      <= '{mux: mode_mux, bus8: mode_b8, wt: wait_i,
                            dly: rw_dly_i, trist: tri_gap_i, rdy_en: rdy_en_i};
            addr_q     <= addr_m;
            wdata_q    <= wdata_i;
            we_q       <= we_i;
            ale_more_q <= ale_long_i;
            state_q    <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (ale_more_q) ale_more_q <= 1'b0;
          else            state_q    <= cfg_q.dly ? ST_DLY : ST_STRB;
        end
        ST_DLY: state_q <= ST_STRB;
        ST_STRB: if (strb_end) begin
          if (we_q) begin
            state_q <= ST_HOLD;
          end else begin
            rdata_q <= cfg_q.bus8 ? {{(DW-HB){1'b0}}, ad_i[HB-1:0]} : ad_i;
            if (cfg_q.trist) begin
              state_q <= ST_TRI;
            end else begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end
          end
        end
        ST_HOLD, ST_TRI: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  ebc_port_mux #(.AW(AW), .DW(DW)) u_port (
    .ph_addr_i (state_q == ST_ADDR),
    .ph_wdrv_i (we_q && ((state_q == ST_DLY) || (state_q == ST_STRB) ||
                         (state_q == ST_HOLD))),
    .mux_i     (cfg_q.mux),
    .bus8_i    (cfg_q.bus8),
    .addr_i    (addr_q),
    .wdata_i   (wdata_q),
    .ad_o      (ad_o),
    .ad_oe_o   (ad_oe_o)
  );

  assign busy_o  = (state_q != ST_IDLE);
  assign addr_o  = busy_o ? addr_q : '0;
  assign ale_o   = (state_q == ST_ADDR);
  assign rd_o    = (state_q == ST_STRB) && !we_q;
  assign wr_o    = (state_q == ST_STRB) && we_q;
  assign done_o  = done_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/ebc_seq_chk.sv
module ebc_seq_chk #(
  parameter int AW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ale_o,
  input logic          rd_o,
  input logic          wr_o,
  input logic          ad_oe_o,
  input logic          done_o,
  input logic          busy_o,
  input logic [AW-1:0] addr_o,
  input logic          mux_q
);
  // R5
  ale_strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> !(rd_o || wr_o));
  // R12
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  wr_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> ad_oe_o);
  // R9
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_o) |-> ad_oe_o);
  // R10
  dmx_rd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o && !mux_q) |-> !ad_oe_o);
  // R3
  dmx_ale_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_o && !mux_q) |-> !ad_oe_o);
  // R4
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(addr_o));
  // R11
  rd_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_o) |-> !ad_oe_o);
endmodule

bind ebc_seq ebc_seq_chk #(.AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ale_o   (ale_o),
  .rd_o    (rd_o),
  .wr_o    (wr_o),
  .ad_oe_o (ad_oe_o),
  .done_o  (done_o),
  .busy_o  (busy_o),
  .addr_o  (addr_o),
  .mux_q   (cfg_q.mux)
);

// File: tb/ebc_seq_tb.sv
`timescale 1ns/1ps
module ebc_seq_tb;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req_i = 0, we_i = 0, ale_long_i = 0, rw_dly_i = 0, tri_gap_i = 0, rdy_en_i = 0;
  logic [23:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [2:0]  mode_i = '0;
  logic [1:0]  aw_sel_i = '0;
  logic [3:0]  wait_i = '0;
  logic        busy_o, done_o, ad_oe_o, ale_o, rd_o, wr_o, rdy_i;
  logic [15:0] rdata_o, ad_o, ad_i;
  logic [23:0] addr_o;

  int n_chk = 0, n_bad = 0;
  int rdy_need = 1000, k_strb = 0;

  typedef struct {
    int ale, gap, strb, lat;
    bit we, mux, ext;
    logic [23:0] addr;
    logic [15:0] wd, rd;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  ebc_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .mode_i(mode_i), .aw_sel_i(aw_sel_i), .wait_i(wait_i),
    .ale_long_i(ale_long_i), .rw_dly_i(rw_dly_i), .tri_gap_i(tri_gap_i),
    .rdy_en_i(rdy_en_i), .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
    .addr_o(addr_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .ad_i(ad_i), .ale_o(ale_o),
    .rd_o(rd_o), .wr_o(wr_o), .rdy_i(rdy_i)
  );

  // memory model: read data derived from the address on the dedicated port
  assign ad_i = rd_o ? (addr_o[15:0] ^ 16'h5A3C) : 16'h0000;

  task automatic chk(input bit ok, input string r, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] md, input logic [1:0] aw, input bit we,
                     input logic [23:0] a, input logic [15:0] wd, input int w,
                     input bit al, input bit dl, input bit tg, input bit re,
                     input int rx, input bit poke);
    exp_t e;
    logic [23:0] am;
    logic [15:0] v;
    bit b8;
    e.ext = (md >= 1) && (md <= 4);
    e.mux = (md == 2) || (md == 3);
    b8    = (md == 3) || (md == 4);
    am = (aw == 0) ? (a & 24'h00FFFF) : (aw == 1) ? (a & 24'h03FFFF) :
         (aw == 2) ? (a & 24'h0FFFFF) : a;
    e.addr = am;
    e.we   = we;
    e.wd   = b8 ? {8'h00, wd[7:0]} : wd;
    v      = am[15:0] ^ 16'h5A3C;
    e.rd   = !e.ext ? 16'h0 : (b8 ? {8'h00, v[7:0]} : v);
    e.ale  = e.ext ? (al ? 2 : 1) : 0;
    e.gap  = e.ext ? int'(dl) : 0;
    e.strb = e.ext ? 1 + w + (re ? rx : 0) : 0;
    e.lat  = e.ext ? e.ale + e.gap + e.strb + (we ? 1 : int'(tg)) : 0;
    @(posedge clk); #1;
    rdy_need = re ? 1 + w + rx : 1000;
    q.push_back(e);
    mode_i = md; aw_sel_i = aw; we_i = we; addr_i = a; wdata_i = wd;
    wait_i = 4'(w); ale_long_i = al; rw_dly_i = dl; tri_gap_i = tg; rdy_en_i = re;
    req_i = 1'b1;
    @(posedge clk); #1;
    req_i = 1'b0;
    if (poke) begin
      repeat (2) @(posedge clk);
      #1 req_i = 1'b1; addr_i = ~a; wdata_i = ~wd; we_i = ~we;
      @(posedge clk); #1 req_i = 1'b0;
    end
    wait (q.size() == 0);
    repeat (2) @(posedge clk);
  endtask

  // monitor / scoreboard
  bit armed = 0, prev_wr = 0;
  int lat, n_ale, n_gap, n_str, pin_bad;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (armed) begin
        lat++;
        if (ale_o) begin
          n_ale++;
          if (q[0].mux && (ad_oe_o !== 1'b1 || ad_o !== q[0].addr[15:0])) pin_bad++;
        end
        if (!ale_o && !rd_o && !wr_o && n_ale > 0 && n_str == 0) n_gap++;
        if (rd_o || wr_o) n_str++;
        if ((wr_o || (prev_wr && !wr_o)) && (ad_oe_o !== 1'b1 || ad_o !== q[0].wd)) pin_bad++;
        if (!q[0].we && !q[0].mux && ad_oe_o) pin_bad++;
        if (busy_o && addr_o !== q[0].addr) pin_bad++;
        prev_wr = wr_o;
        if (done_o) begin
          chk(lat - 1 == q[0].lat, "R11", "done latency", lat - 1, q[0].lat);
          chk(n_ale == q[0].ale, "R5", "ale length", n_ale, q[0].ale);
          chk(n_gap == q[0].gap, "R6", "strobe delay", n_gap, q[0].gap);
          chk(n_str == q[0].strb, "R7/R8", "strobe length", n_str, q[0].strb);
          chk(pin_bad == 0, "R3/R4/R9/R10", "pin cycles wrong", pin_bad, 0);
          if (!q[0].we)
            chk(rdata_o === q[0].rd, "R10/R2", "read data", rdata_o, q[0].rd);
          void'(q.pop_front());
          armed = 0;
        end
      end else begin
        if (done_o) chk(1'b0, "R12", "spurious done", 1, 0);
        if (req_i && !busy_o && q.size() > 0) begin
          armed = 1; lat = 0; n_ale = 0; n_gap = 0; n_str = 0; pin_bad = 0; prev_wr = 0;
        end
      end
      if (rd_o || wr_o) k_strb++; else k_strb = 0;
      rdy_i = (k_strb > 0) && (k_strb >= rdy_need);
    end else begin
      rdy_i = 1'b0;
    end
  end

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy_o && !done_o && !ale_o && !rd_o && !wr_o && !ad_oe_o, "R1", "reset outputs",
        {busy_o, done_o, ale_o, rd_o, wr_o, ad_oe_o}, 0);
    //  md aw we addr       wd       w  al dl tg re rx poke
    run(1, 3, 0, 24'hABCDEF, 16'h0,   0, 0, 0, 0, 0, 0, 0); // R3 R10 demux16 read
    run(2, 2, 1, 24'hFEDCBA, 16'h1234, 2, 1, 1, 0, 0, 0, 0); // R4 R5 R6 R9 mux16 write
    run(3, 1, 0, 24'h7F1357, 16'h0,   1, 0, 1, 1, 0, 0, 0); // R3 R11 mux8 read
    run(4, 0, 1, 24'h9A55AA, 16'hBEEF, 15, 0, 0, 0, 0, 0, 0); // R7 R9 demux8 write
    run(2, 3, 0, 24'h123456, 16'h0,   1, 0, 0, 0, 1, 3, 0); // R8 ready stretch
    run(1, 3, 1, 24'h00C0DE, 16'hCAFE, 2, 0, 0, 0, 0, 0, 0); // R8 ready ignored
    run(0, 3, 0, 24'h111111, 16'h0,   3, 1, 1, 1, 0, 0, 0); // R2 single chip
    run(6, 3, 1, 24'h222222, 16'h5555, 0, 0, 0, 0, 0, 0, 0); // R2 reserved code
    run(1, 2, 0, 24'h3C3C3C, 16'h0,   6, 1, 0, 0, 0, 0, 1); // R12 request while busy
    run(4, 3, 0, 24'hF0F0F0, 16'h0,   0, 1, 1, 1, 1, 2, 0); // R8 R10 R11 demux8 read
    run(3, 2, 1, 24'h0A0B0C, 16'hA1B2, 0, 1, 0, 0, 1, 0, 0); // R9 mux8 write, ready high
    repeat (4) @(negedge clk);
    // R12 no leftover activity after the poke test
    chk(!busy_o && !done_o, "R12", "idle at end", {busy_o, done_o}, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule